// File: doc/BRIEF.md
# Segment-Offset Byte/Word Memory Port

This block is a byte-addressed memory reached through a pair of 16-bit values: a segment and an offset. The segment value names a paragraph, which is a 16-byte-aligned base. The block computes the base as the segment times 16. It adds the offset to that base to form a 20-bit physical address. The physical space is one megabyte, and any carry past bit 19 is dropped.

Each request is a single-cycle access of either one byte or one 16-bit word. A word is kept in little-endian order: its low byte sits at the physical address and its high byte at the next address. When the address is the last byte of the space, the high byte wraps to physical address zero.

The storage is scaled down for simulation to 2^MEM_AW bytes (default 1024). Physical addresses alias modulo that size. It is split into an even-address bank and an odd-address bank, so a word that straddles any two neighbouring bytes completes in one cycle. Read data is registered and comes back one clock after the request, qualified by a valid flag.

Top module: `seg_mem_port`

## Requirements
- R1: `paddr_o` equals (`seg_i` * 16 + `off_i`) modulo 2^20, combinationally, for every input pair.
- R2: Segment 0x038E with offset 0x0032 gives physical address 0x03912.
- R3: A word write (`word_i`=1) stores `wdata_i[7:0]` at physical address p and `wdata_i[15:8]` at p+1. A word read returns the byte at p in `rdata_o[7:0]` and the byte at p+1 in `rdata_o[15:8]`.
- R4: A byte write (`word_i`=0) changes only the byte at p, taking `wdata_i[7:0]`. The byte at p+1 keeps its value.
- R5: A byte read returns the byte at p in `rdata_o[7:0]` and zero in `rdata_o[15:8]`.
- R6: A word access at physical address 0xFFFFF uses physical address 0x00000 for its high byte.
- R7: `rvalid_o` is 1 in the cycle after an accepted read (`req_i`=1, `we_i`=0) and 0 in every other cycle, including after writes and idle cycles.
- R8: While `rst_ni` is low, `rvalid_o` is 0 and `rdata_o` is 0.
- R9: `rdata_o` holds its last value in every cycle where `rvalid_o` is 0.
- R10: The byte at physical address p is stored at p modulo 2^MEM_AW (default 1024). Addresses that differ only above bit MEM_AW-1 name the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| seg_i | input | 16 | Segment value (paragraph number) |
| off_i | input | 16 | Offset within the segment |
| wdata_i | input | 16 | Write data; low byte only for byte writes |
| paddr_o | output | 20 | Physical address of the current request |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |

## Verification
The bench aims at the straddle cases:
- A word at an odd address. A design that picked the wrong bank or row would swap bytes or corrupt the neighbouring word.
- A word at 0xFFFFF. Without the 20-bit wrap, the high byte would land at the wrong row.
- Byte writes next to known data. A design that always enabled both banks would clobber the neighbour byte.
- Byte reads after word writes. Leaking the stale high lane would show a nonzero upper byte.
- The documented 0x038E:0x0032 example and segment sums that overflow 20 bits. These catch a shift by the wrong amount or a carry kept past bit 19.
- Mixed random traffic, compared each clock against a behavioural byte model. This exposes a valid flag raised on writes or read data that drifts between reads.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;
  localparam int unsigned PARA_SHIFT = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_BANKS  = 2;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_mem_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o,
  output logic [PA_W-1:0]  pa_nx_o
);
  localparam int unsigned BASE_W = SEG_W + PARA_SHIFT;

  logic [BASE_W-1:0] base;

  assign base    = {seg_i, {PARA_SHIFT{1'b0}}};
  // truncation to PA_W gives the modulo-2^PA_W wrap
  assign pa_o    = PA_W'(base) + PA_W'(off_i);
  assign pa_nx_o = pa_o + PA_W'(1);
endmodule

// File: rtl/seg_lane_split.sv
module seg_lane_split
  import seg_mem_pkg::*;
#(
  parameter int unsigned PA_W   = 20,
  parameter int unsigned MEM_AW = 10
) (
  input  logic [PA_W-1:0]                      pa_i,
  input  logic [PA_W-1:0]                      pa_nx_i,
  input  logic                                 wr_i,
  input  logic                                 word_i,
  input  logic [2*BYTE_W-1:0]                  wdata_i,
  output logic [NUM_BANKS-1:0][MEM_AW-2:0]     row_o,
  output logic [NUM_BANKS-1:0]                 wen_o,
  output logic [NUM_BANKS-1:0][BYTE_W-1:0]     wbyte_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic lo_here;
    // bank b holds the low byte when the address parity matches b
    assign lo_here    = (pa_i[0] == 1'(b));
    assign row_o[b]   = lo_here ? pa_i[MEM_AW-1:1] : pa_nx_i[MEM_AW-1:1];
    assign wen_o[b]   = wr_i & (lo_here | word_i);
    assign wbyte_o[b] = lo_here ? wdata_i[BYTE_W-1:0] : wdata_i[2*BYTE_W-1:BYTE_W];
  end
endmodule

// File: rtl/seg_byte_bank.sv
module seg_byte_bank
  import seg_mem_pkg::*;
#(
  parameter int unsigned ROW_W = 9
) (
  input  logic              clk_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wen_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] rbyte_o
);
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [BYTE_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (wen_i) mem_q[row_i] <= wbyte_i;
  end

  assign rbyte_o = mem_q[row_i];
endmodule

// File: rtl/seg_mem_port.sv
module seg_mem_port
  import seg_mem_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned PA_W   = 20,
  parameter int unsigned MEM_AW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               word_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [15:0]        wdata_i,
  output logic [PA_W-1:0]    paddr_o,
  output logic [15:0]        rdata_o,
  output logic               rvalid_o
);
  localparam int unsigned ROW_W = MEM_AW - 1;

  logic [PA_W-1:0]                  pa_nx;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  row;
  logic [NUM_BANKS-1:0]             wen;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] wbyte;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] rbyte;
  logic [BYTE_W-1:0]                lo_byte, hi_byte;
  logic                             rd;

  seg_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_addr (
    .seg_i   (seg_i),
    .off_i   (off_i),
    .pa_o    (paddr_o),
    .pa_nx_o (pa_nx)
  );

  seg_lane_split #(.PA_W(PA_W), .MEM_AW(MEM_AW)) i_split (
    .pa_i    (paddr_o),
    .pa_nx_i (pa_nx),
    .wr_i    (req_i & we_i),
    .word_i  (word_i),
    .wdata_i (wdata_i),
    .row_o   (row),
    .wen_o   (wen),
    .wbyte_o (wbyte)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    seg_byte_bank #(.ROW_W(ROW_W)) i_bank (
      .clk_i   (clk_i),
      .row_i   (row[b]),
      .wen_i   (wen[b]),
      .wbyte_i (wbyte[b]),
      .rbyte_o (rbyte[b])
    );
  end

  assign rd      = req_i & ~we_i;
  assign lo_byte = rbyte[paddr_o[0]];
  assign hi_byte = word_i ? rbyte[~paddr_o[0]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= {hi_byte, lo_byte};
    end
  end
endmodule

// File: rtl/seg_mem_port_chk.sv
module seg_mem_port_chk #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned PA_W  = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             word_i,
  input logic [SEG_W-1:0] seg_i,
  input logic [OFF_W-1:0] off_i,
  input logic [PA_W-1:0]  paddr_o,
  input logic [15:0]      rdata_o,
  input logic             rvalid_o
);
  a_r1_paddr_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> paddr_o == PA_W'(PA_W'(seg_i) * PA_W'(16) + PA_W'(off_i)));

  a_r2_known_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_i == 16'h038E && off_i == 16'h0032) |-> paddr_o == 20'h03912);

  a_r7_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  a_r7_no_valid_else: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  a_r9_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));

  a_r5_byte_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !word_i) |=> rdata_o[15:8] == 8'h00);
endmodule

bind seg_mem_port seg_mem_port_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .word_i   (word_i),
  .seg_i    (seg_i),
  .off_i    (off_i),
  .paddr_o  (paddr_o),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o)
);

// File: tb/test_seg_mem_port.sv
`timescale 1ns/1ps
module test_seg_mem_port;
  localparam int MEM_AW = 10;
  localparam int MSIZE  = 1 << MEM_AW;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [15:0] seg_i = '0, off_i = '0, wdata_i = '0;
  logic [19:0] paddr_o;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  model [MSIZE];
  logic        exp_valid = 1'b0;
  logic [15:0] exp_data  = '0;
  string       exp_tag   = "R8";

  always #2.5 clk_i = ~clk_i;

  seg_mem_port #(.MEM_AW(MEM_AW)) i_seg_mem_port (
    .clk_i, .rst_ni, .req_i, .we_i, .word_i, .seg_i, .off_i, .wdata_i,
    .paddr_o, .rdata_o, .rvalid_o
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic int pa_of(logic [15:0] s, logic [15:0] o);
    return (int'(s) * 16 + int'(o)) & 32'hFFFFF;
  endfunction

  // one clock: check the previous op's result, then present a new op
  task automatic step(logic rq, logic w, logic wd, logic [15:0] s, logic [15:0] o,
                      logic [15:0] d, string tag);
    int p, q;
    @(negedge clk_i);
    chk("R7", "rvalid", 32'(rvalid_o), 32'(exp_valid));
    chk(exp_valid ? exp_tag : "R9", "rdata", 32'(rdata_o), 32'(exp_data));
    req_i = rq; we_i = w; word_i = wd; seg_i = s; off_i = o; wdata_i = d;
    #1;
    p = pa_of(s, o);
    q = (p + 1) & 32'hFFFFF;
    if (rq) chk("R1", "paddr", 32'(paddr_o), 32'(p));
    exp_valid = rq && !w;
    if (rq && !w) begin
      exp_tag  = tag;
      exp_data = {wd ? model[q % MSIZE] : 8'h00, model[p % MSIZE]};
    end
    if (rq && w) begin
      model[p % MSIZE] = d[7:0];
      if (wd) model[q % MSIZE] = d[15:8];
    end
  endtask

  initial begin
    #500_000;
    errors++;
    $display("FAIL watchdog: timeout got 1 exp 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8", "rvalid in reset", 32'(rvalid_o), 0);
    chk("R8", "rdata in reset", 32'(rdata_o), 0);
    rst_ni = 1'b1;

    // fill all storage with words
    for (int i = 0; i < MSIZE / 2; i++)
      step(1, 1, 1, 16'h0000, 16'(2 * i), 16'(i * 16'h0137 + 16'h5A0F), "R3");

    // R2: documented example
    step(0, 0, 0, 16'h038E, 16'h0032, 16'h0, "R2");
    #1 chk("R2", "paddr example", 32'(paddr_o), 32'h03912);

    // R1: sum carrying past bit 19 wraps
    step(1, 0, 1, 16'hFFFF, 16'hFFFF, 16'h0, "R1");

    // R3: word at odd address, read back as word and as bytes
    step(1, 1, 1, 16'h0001, 16'h0003, 16'hBEEF, "R3");
    step(1, 0, 1, 16'h0001, 16'h0003, 16'h0, "R3");
    step(1, 0, 0, 16'h0001, 16'h0003, 16'h0, "R3");
    step(1, 0, 0, 16'h0001, 16'h0004, 16'h0, "R3");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    #1 chk("R3", "low byte at p", 32'(rdata_o), 32'h00BE);

    // R4: byte write leaves neighbour
    step(1, 1, 0, 16'h0002, 16'h0006, 16'hAA11, "R4");
    step(1, 0, 1, 16'h0002, 16'h0006, 16'h0, "R4");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    #1 chk("R4", "neighbour kept", 32'(rdata_o[7:0]), 32'h11);

    // R5: byte read after word write
    step(1, 1, 1, 16'h0003, 16'h0000, 16'hC3A5, "R5");
    step(1, 0, 0, 16'h0003, 16'h0000, 16'h0, "R5");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    #1 chk("R5", "zero-extend", 32'(rdata_o), 32'h00A5);

    // R6: word at 0xFFFFF wraps its high byte to 0x00000
    step(1, 1, 1, 16'hF000, 16'hFFFF, 16'h7E81, "R6");
    step(1, 0, 0, 16'h0000, 16'h0000, 16'h0, "R6");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    #1 chk("R6", "high byte at 0", 32'(rdata_o), 32'h007E);
    step(1, 0, 1, 16'hF000, 16'hFFFF, 16'h0, "R6");

    // R10: aliasing above MEM_AW
    step(1, 1, 0, 16'h0040, 16'h0000, 16'h0033, "R10");
    step(1, 0, 0, 16'h0000, 16'h0000, 16'h0, "R10");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    #1 chk("R10", "alias byte", 32'(rdata_o), 32'h0033);

    // R7: writes and idles never raise valid
    step(1, 1, 1, 16'h0005, 16'h0010, 16'h1234, "R7");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R7");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic rq, w, wd;
      rq = ($urandom % 8) != 0;
      w  = $urandom % 2;
      wd = $urandom % 2;
      step(rq, w, wd, 16'($urandom), 16'($urandom), 16'($urandom), wd ? "R3" : "R5");
    end
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");
    step(0, 0, 0, 16'h0, 16'h0, 16'h0, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule